// File: doc/BRIEF.md
# Frame CRC-16 Encoder and Checker

This block protects serial transfer frames with a 16-bit frame error control field. The encoder side takes the message bits of a frame one per handshake, passes them straight to its output stream, and once the last message bit is taken it emits the 16 check bits, most significant register cell first. During those 16 bits it is busy and takes no new input. The checker side takes a whole received frame, check bits included, and one cycle after the final bit reports completion together with an error flag that is set whenever the remainder is not zero.

Both sides run a bit-serial shift register built on the generator X^16 + X^12 + X^5 + 1. Every cell is set to one at each frame start, so a frame of zeros still moves the register and yields check bits that are not zero. A frame start strobe reloads this preset at any time. The register also returns to the preset on its own when a frame closes, so frames may follow each other without a strobe.

Top module: `frame_crc16`

## Requirements
- R1: For a message of k bits taken first bit first, the encoder emits 16 check bits equal to (X^16·M(X) + X^k·L(X)) mod G(X), where G(X) = X^16 + X^12 + X^5 + 1 and L(X) is the all-ones polynomial of degree 15. The bits are emitted highest-degree coefficient first, directly after the last message bit. enc_out_last_o is 1 on the sixteenth check bit only. A 72-bit message made of the ASCII bytes "123456789", each byte sent most significant bit first, yields 0x29B1.
- R2: Message bits appear on the encoder output unchanged and in order. enc_ready_o is 1 only when enc_out_ready_i is 1, the block is not busy and no start strobe is present.
- R3: Accepting the bit marked last starts exactly 16 check bit beats. enc_busy_o is 1 while those beats are pending, and enc_ready_o stays 0 during that time.
- R4: A start strobe on either side reloads the all-ones preset whatever the current state. On the encoder it also ends any pending check bits, so enc_busy_o is 0 in the following cycle. Bits fed before the strobe have no effect on the next frame's result.
- R5: chk_done_o pulses for exactly one cycle, in the cycle after the checker accepts the bit marked last. chk_err_o is meaningful in that cycle and equals 1 exactly when (X^16·C(X) + X^n·L(X)) mod G(X) is not zero over all n received bits.
- R6: A frame built from a message and its encoder check bits is reported with chk_err_o = 0. The same frame with any one bit inverted is reported with chk_err_o = 1.
- R7: A 16-bit frame of all zeros is reported with chk_err_o = 1, because of the all-ones preset.
- R8: While check bits are pending and enc_out_ready_i is 0, enc_out_valid_o stays 1 and enc_out_data_o holds its value.
- R9: After reset, enc_busy_o, chk_done_o and chk_err_o are 0 and chk_ready_o is 1.
- R10: After a frame closes, the next frame may begin with no start strobe and gives the same result as with one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_sof_i | input | 1 | Encoder frame start strobe; reloads the preset |
| enc_valid_i | input | 1 | Encoder message bit valid |
| enc_data_i | input | 1 | Encoder message bit |
| enc_last_i | input | 1 | Marks the final message bit |
| enc_ready_o | output | 1 | Encoder accepts a message bit |
| enc_out_valid_o | output | 1 | Encoder output bit valid |
| enc_out_data_o | output | 1 | Encoder output bit (message, then check bits) |
| enc_out_last_o | output | 1 | Marks the final check bit |
| enc_out_ready_i | input | 1 | Downstream accepts an output bit |
| enc_busy_o | output | 1 | Check bits pending; no input taken |
| chk_sof_i | input | 1 | Checker frame start strobe; reloads the preset |
| chk_valid_i | input | 1 | Checker received bit valid |
| chk_data_i | input | 1 | Checker received bit |
| chk_last_i | input | 1 | Marks the final received bit (last check bit) |
| chk_ready_o | output | 1 | Checker accepts a bit |
| chk_done_o | output | 1 | One-cycle pulse after the final bit |
| chk_err_o | output | 1 | Nonzero remainder, valid with chk_done_o |

## Verification
The bench builds the block with its defaults: a 16-cell register, generator 0x1021 and the all-ones preset. That small message space allows every message of 1 to 8 bits to be sent through the encoder under a rotating downstream stall pattern. Each encoded frame is then fed to the checker, both intact and with one bit inverted at a position that moves across the frame. Expected check bits and remainders come from a polynomial long division written in the bench. A 72-bit known word, an all-zero frame, and start strobes issued mid-frame and during the check bit phase reach the preset and abort paths.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W_DEF = 16;
  localparam logic [15:0] CRC_POLY_DEF = 16'h1021;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_FECF = 1'b1
  } enc_phase_e;
endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter bit PRESET_ONES = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         zero_fb_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] PRESET = PRESET_ONES ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] q, base, stepped, d;
  logic         fb;

  // load and shift together: step from the preset
  always_comb begin
    base    = load_i ? PRESET : q;
    fb      = !zero_fb_i && (bit_i ^ base[W-1]);
    stepped = {base[W-2:0], 1'b0} ^ (fb ? POLY : {W{1'b0}});
    d       = shift_i ? stepped : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= PRESET;
    else         q <= d;
  end

  assign state_o = q;

  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !shift_i |=> q == PRESET); // R4
endmodule

// File: rtl/fecf_encoder.sv
module fecf_encoder
  import crc_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter bit PRESET_ONES = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic valid_i,
  input  logic data_i,
  input  logic last_i,
  output logic ready_o,
  output logic out_valid_o,
  output logic out_data_o,
  output logic out_last_o,
  input  logic out_ready_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(W - 1);

  enc_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     state;
  logic             in_fire, fecf_fire, fecf_end;

  assign busy_o      = (phase_q == PH_FECF);
  assign ready_o     = !sof_i && !busy_o && out_ready_i;
  assign out_valid_o = !sof_i && (busy_o || valid_i);
  assign out_data_o  = busy_o ? state[W-1] : data_i;
  assign out_last_o  = busy_o && (cnt_q == CNT_END);

  assign in_fire   = valid_i && ready_o;
  assign fecf_fire = busy_o && out_ready_i && !sof_i;
  assign fecf_end  = fecf_fire && (cnt_q == CNT_END);

  crc_lfsr #(.W(W), .POLY(POLY), .PRESET_ONES(PRESET_ONES)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sof_i || fecf_end),
    .shift_i   (in_fire || (fecf_fire && !fecf_end)),
    .bit_i     (data_i),
    .zero_fb_i (busy_o),
    .state_o   (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
    end else if (sof_i) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
    end else if (in_fire && last_i) begin
      phase_q <= PH_FECF;
      cnt_q   <= '0;
    end else if (fecf_fire) begin
      if (fecf_end) phase_q <= PH_DATA;
      cnt_q <= fecf_end ? '0 : cnt_q + 1'b1;
    end
  end

  AST_FECF_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !out_ready_i && !sof_i |=> busy_o && out_valid_o && $stable(out_data_o)); // R8
  AST_BUSY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(in_fire && last_i)); // R3
  AST_SOF_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !busy_o); // R4
  AST_FECF_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q == CNT_END |-> state[W-2:0] == '0); // R1
endmodule

// File: rtl/fecf_checker.sv
module fecf_checker #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter bit PRESET_ONES = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic valid_i,
  input  logic data_i,
  input  logic last_i,
  output logic ready_o,
  output logic done_o,
  output logic err_o
);
  logic [W-1:0] state;
  logic         fire, fin_q;

  assign ready_o = !sof_i;
  assign fire    = valid_i && !sof_i;

  // register holds the syndrome in the cycle after the final bit
  crc_lfsr #(.W(W), .POLY(POLY), .PRESET_ONES(PRESET_ONES)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sof_i || fin_q),
    .shift_i   (fire),
    .bit_i     (data_i),
    .zero_fb_i (1'b0),
    .state_o   (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fin_q <= 1'b0;
    else         fin_q <= fire && last_i;
  end

  assign done_o = fin_q;
  assign err_o  = fin_q && (state != '0);

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && ready_o && last_i)); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R5
endmodule

// File: rtl/frame_crc16.sv
module frame_crc16
  import crc_pkg::*;
#(
  parameter int unsigned W = CRC_W_DEF,
  parameter logic [W-1:0] POLY = CRC_POLY_DEF,
  parameter bit PRESET_ONES = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enc_sof_i,
  input  logic enc_valid_i,
  input  logic enc_data_i,
  input  logic enc_last_i,
  output logic enc_ready_o,
  output logic enc_out_valid_o,
  output logic enc_out_data_o,
  output logic enc_out_last_o,
  input  logic enc_out_ready_i,
  output logic enc_busy_o,
  input  logic chk_sof_i,
  input  logic chk_valid_i,
  input  logic chk_data_i,
  input  logic chk_last_i,
  output logic chk_ready_o,
  output logic chk_done_o,
  output logic chk_err_o
);
  fecf_encoder #(.W(W), .POLY(POLY), .PRESET_ONES(PRESET_ONES)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (enc_sof_i),
    .valid_i     (enc_valid_i),
    .data_i      (enc_data_i),
    .last_i      (enc_last_i),
    .ready_o     (enc_ready_o),
    .out_valid_o (enc_out_valid_o),
    .out_data_o  (enc_out_data_o),
    .out_last_o  (enc_out_last_o),
    .out_ready_i (enc_out_ready_i),
    .busy_o      (enc_busy_o)
  );

  fecf_checker #(.W(W), .POLY(POLY), .PRESET_ONES(PRESET_ONES)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sof_i   (chk_sof_i),
    .valid_i (chk_valid_i),
    .data_i  (chk_data_i),
    .last_i  (chk_last_i),
    .ready_o (chk_ready_o),
    .done_o  (chk_done_o),
    .err_o   (chk_err_o)
  );

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_busy_o && enc_valid_i |=> $stable(enc_busy_o) || $past(enc_sof_i || enc_out_ready_i)); // R3
endmodule

// File: tb/frame_crc16_test.sv
module frame_crc16_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_sof = 0, enc_valid = 0, enc_data = 0, enc_last = 0, enc_out_ready = 0;
  logic enc_ready, enc_out_valid, enc_out_data, enc_out_last, enc_busy;
  logic chk_sof = 0, chk_valid = 0, chk_data = 0, chk_last = 0;
  logic chk_ready, chk_done, chk_err;

  int checks = 0, failures = 0;
  bit msg   [0:127];
  bit cbits [0:127];
  bit obits [0:127];
  bit olast [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_crc16 uut (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_sof_i(enc_sof), .enc_valid_i(enc_valid), .enc_data_i(enc_data), .enc_last_i(enc_last),
    .enc_ready_o(enc_ready), .enc_out_valid_o(enc_out_valid), .enc_out_data_o(enc_out_data),
    .enc_out_last_o(enc_out_last), .enc_out_ready_i(enc_out_ready), .enc_busy_o(enc_busy),
    .chk_sof_i(chk_sof), .chk_valid_i(chk_valid), .chk_data_i(chk_data), .chk_last_i(chk_last),
    .chk_ready_o(chk_ready), .chk_done_o(chk_done), .chk_err_o(chk_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // (X^16*B + X^len*L) mod G by long division, B given first bit = highest degree
  function automatic logic [15:0] ref_rem(input int len, input bit b [0:127]);
    bit d [0:159];
    logic [15:0] r;
    for (int i = 0; i < 160; i++) d[i] = 1'b0;
    for (int i = 0; i < len; i++) d[len+15-i] ^= b[i];
    for (int j = 0; j < 16; j++) d[len+j] ^= 1'b1;
    for (int deg = len + 15; deg >= 16; deg--) begin
      if (d[deg]) begin
        d[deg] ^= 1'b1; d[deg-4] ^= 1'b1; d[deg-11] ^= 1'b1; d[deg-16] ^= 1'b1;
      end
    end
    for (int j = 0; j < 16; j++) r[j] = d[j];
    return r;
  endfunction

  task automatic run_enc(input int k, input bit do_sof, output logic [15:0] fecf,
                         output bit data_ok, output bit last_ok, output bit busy_ok);
    int idx = 0, got = 0, guard = 0;
    data_ok = 1; last_ok = 1; busy_ok = 1; fecf = '0;
    if (do_sof) begin
      enc_sof = 1; @(negedge clk); enc_sof = 0;
    end
    while (got < k + 16 && guard < 2000) begin
      enc_valid     = (idx < k);
      enc_data      = (idx < k) ? msg[idx] : 1'b0;
      enc_last      = (idx == k - 1);
      enc_out_ready = ((guard * 3 + k) % 4) != 0;
      #1;
      if (enc_busy && enc_ready) busy_ok = 0;
      if (enc_out_valid && enc_out_ready) begin
        obits[got] = enc_out_data; olast[got] = enc_out_last; got++;
      end
      if (enc_valid && enc_ready) idx++;
      @(negedge clk);
      guard++;
    end
    enc_valid = 0; enc_last = 0; enc_out_ready = 0;
    if (got < k + 16) begin data_ok = 0; last_ok = 0; end
    for (int i = 0; i < k; i++) if (obits[i] != msg[i]) data_ok = 0;
    for (int j = 0; j < 16; j++) fecf[15-j] = obits[k+j];
    for (int i = 0; i < k + 16; i++) if (olast[i] != (i == k + 15)) last_ok = 0;
  endtask

  task automatic run_chk(input int n, input bit do_sof, output bit done_ok,
                         output bit err, output bit early_ok);
    int idx = 0, guard = 0;
    early_ok = 1;
    if (do_sof) begin
      chk_sof = 1; #1; if (chk_ready) early_ok = 0; @(negedge clk); chk_sof = 0;
    end
    while (idx < n && guard < 2000) begin
      chk_valid = ((guard + n) % 3) != 2;
      chk_data  = cbits[idx];
      chk_last  = (idx == n - 1);
      #1;
      if (chk_done) early_ok = 0;
      if (chk_valid && chk_ready) idx++;
      @(negedge clk);
      guard++;
    end
    chk_valid = 0; chk_last = 0;
    #1;
    done_ok = chk_done;
    err     = chk_err;
    @(negedge clk);
    #1;
    if (chk_done) done_ok = 0;
  endtask

  task automatic chk_garbage(input int g);
    for (int i = 0; i < g; i++) begin
      chk_valid = 1; chk_data = i[0] ^ i[1]; chk_last = 0;
      @(negedge clk);
    end
    chk_valid = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] fecf, exp_fecf, exp_rem;
    bit dok, lok, bok, d_ok, err, eok;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R9 reset state
    check(enc_busy == 0, "R9 enc_busy after reset", enc_busy, 0);
    check(chk_done == 0 && chk_err == 0, "R9 chk_done/chk_err after reset", {chk_done, chk_err}, 0);
    check(chk_ready == 1, "R9 chk_ready after reset", chk_ready, 1);
    @(negedge clk);

    // R1 known 72-bit word "123456789"
    for (int c = 0; c < 9; c++) begin
      logic [7:0] ch;
      ch = 8'h31 + 8'(c);
      for (int b = 0; b < 8; b++) msg[c*8+b] = ch[7-b];
    end
    run_enc(72, 1, fecf, dok, lok, bok);
    check(fecf == 16'h29B1, "R1 known word check bits", fecf, 16'h29B1);
    check(ref_rem(72, msg) == 16'h29B1, "R1 bench reference on known word", ref_rem(72, msg), 16'h29B1);
    check(dok, "R2 known word passthrough", dok, 1);

    // exhaustive messages of 1..8 bits
    for (int k = 1; k <= 8; k++) begin
      for (int m = 0; m < (1 << k); m++) begin
        int n, pos;
        for (int i = 0; i < k; i++) msg[i] = m[k-1-i];
        exp_fecf = ref_rem(k, msg);
        // R10: odd messages start without a strobe
        run_enc(k, (m % 2) == 0, fecf, dok, lok, bok);
        check(fecf == exp_fecf, (m % 2) ? "R10 check bits without strobe" : "R1 check bits", fecf, exp_fecf);
        check(dok, "R2 message passthrough", dok, 1);
        check(lok, "R1 out_last on final check bit", lok, 1);
        check(bok, "R3 no input while busy", bok, 1);

        n = k + 16;
        for (int i = 0; i < k; i++) cbits[i] = msg[i];
        for (int j = 0; j < 16; j++) cbits[k+j] = exp_fecf[15-j];
        exp_rem = ref_rem(n, cbits);
        run_chk(n, (m % 2) == 0, d_ok, err, eok);
        check(d_ok && eok, "R5 done pulse timing", {d_ok, eok}, 2'b11);
        check(err == (exp_rem != 0) && err == 0, "R6 intact frame", err, 0);

        pos = (m * 5 + k) % n;
        cbits[pos] = ~cbits[pos];
        exp_rem = ref_rem(n, cbits);
        run_chk(n, 1, d_ok, err, eok);
        check(err == (exp_rem != 0) && err == 1, "R6 single bit error", err, 1);
      end
    end

    // R7 all-zero 16-bit frame
    for (int i = 0; i < 16; i++) cbits[i] = 0;
    run_chk(16, 1, d_ok, err, eok);
    check(d_ok && err == 1, "R7 all-zero frame flagged", err, 1);

    // R4 checker: garbage then strobe then intact frame
    for (int i = 0; i < 5; i++) msg[i] = i[0];
    exp_fecf = ref_rem(5, msg);
    for (int i = 0; i < 5; i++) cbits[i] = msg[i];
    for (int j = 0; j < 16; j++) cbits[5+j] = exp_fecf[15-j];
    chk_garbage(7);
    run_chk(21, 1, d_ok, err, eok);
    check(d_ok && err == 0 && eok, "R4 checker strobe discards prior bits", {d_ok, err, eok}, 3'b101);

    // R4 encoder: strobe during check bits aborts them
    enc_sof = 1; @(negedge clk); enc_sof = 0;
    for (int i = 0; i < 3; i++) begin
      enc_valid = 1; enc_data = 1; enc_last = (i == 2); enc_out_ready = 1;
      @(negedge clk);
    end
    enc_valid = 0; enc_last = 0;
    @(negedge clk); @(negedge clk); #1;
    check(enc_busy == 1, "R3 busy after last bit", enc_busy, 1);
    enc_sof = 1; @(negedge clk); enc_sof = 0; #1;
    check(enc_busy == 0, "R4 strobe ends check bits", enc_busy, 0);
    run_enc(5, 0, fecf, dok, lok, bok);
    check(fecf == exp_fecf && dok, "R4 frame after abort", fecf, exp_fecf);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule